// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block keeps three flag arrays with one bit per interrupt vector: a request array, an in-service array and a trigger-mode array. It also keeps a task priority and a spurious-vector setting. From this state it forms a processor priority and drives one interrupt-request line toward the processor. The processor takes the interrupt with an acknowledge strobe and later retires it with an end-of-interrupt strobe. For level-triggered vectors, the block can notify upstream interrupt routers that a vector has been retired.

Priority is judged on classes of 16 vectors, given by the top four bits of a vector. The processor priority is the larger of two values: the task priority, and the class of the highest vector in service. A request reaches the processor only when its class is strictly above the class of the processor priority. The one exception is a processor priority of zero, which holds nothing back. When an acknowledge arrives while the only request is held back, the block answers with the programmed spurious vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several requests are set, an acknowledge picks the numerically highest requested vector.
- R2: `ppr_o` equals the task priority when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that in-service class followed by four zero bits. An empty in-service array counts as class 0.
- R3: A request is pending when `ppr_o` is zero, or when the class of the highest request is strictly greater than the class of `ppr_o`. A request of equal or lower class is held back.
- R4: An acknowledge of a pending request clears that request bit and sets its in-service bit. One cycle after `ack_i`, `ack_valid_o` pulses with `ack_none_o`=0 and `ack_vec_o` set to the vector.
- R5: An acknowledge when no request exists gives `ack_none_o`=1. An acknowledge while the highest request is held back gives `ack_none_o`=0 and `ack_vec_o` set to the spurious vector. In both cases the arrays are left unchanged.
- R6: Setting a request with `set_level_i`=1 marks the vector level-triggered, and with 0 marks it edge-triggered. An EOI clears the highest in-service bit. If that vector is level-triggered and directed EOI is off, `eoi_bcast_o` pulses one cycle later with `eoi_vec_o` set to the vector.
- R7: While the directed-EOI flag (`svr_deo_i` at the last spurious write) is 1, an EOI emits no broadcast.
- R8: `irq_o` is 1 only while the enable bit (`svr_wdata_i[8]`) is set and a pending request exists. An acknowledge while disabled returns none and leaves the requests in place.
- R9: When a request and an acknowledge target the same vector in the same cycle, the acknowledge is applied first, so the request bit stays set.
- R10: An EOI with no vector in service changes nothing and emits no broadcast.
- R11: After reset all arrays, the task priority and the spurious setting are zero, so `irq_o` and `ppr_o` are 0.
- R12: A task-priority write takes all 8 bits of `tpr_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 1 | Raise a request for `set_vec_i` |
| set_vec_i | input | 8 | Vector to request |
| set_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority value |
| svr_we_i | input | 1 | Spurious-setting write strobe |
| svr_wdata_i | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| svr_deo_i | input | 1 | Directed-EOI flag, loaded with `svr_we_i` |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Acknowledge result valid (one cycle after `ack_i`) |
| ack_none_o | output | 1 | Acknowledge found no request |
| ack_vec_o | output | 8 | Acknowledged or spurious vector |
| ppr_o | output | 8 | Processor priority |
| eoi_bcast_o | output | 1 | Level-triggered vector retired |
| eoi_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
The bench builds the block with its default 8-bit vector width. The full 256-entry arrays and the real class boundaries are therefore in play. This width lets the bench exercise several things: vectors that differ only in class, such as 0x41 against 0x82; a request class equal to the in-service class, such as 0x75 against 0x70; and a task priority whose low nibble is nonzero, such as 0x3F. Under these conditions the processor priority alternates between its two sources as vectors are taken and retired.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [VEC_W-1:0] set_vec_i,
  input  logic             set_level_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  input  logic             svr_we_i,
  input  logic [VEC_W:0]   svr_wdata_i,
  input  logic             svr_deo_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic             ack_valid_o,
  output logic             ack_none_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             eoi_bcast_o,
  output logic [VEC_W-1:0] eoi_vec_o
);
  localparam int NVEC   = 1 << VEC_W;
  localparam int CLS_LO = VEC_W - 4;

  logic [NVEC-1:0]  req_q, srv_q, lvl_q;
  logic [VEC_W-1:0] tpr_q, spur_q;
  logic             en_q, deo_q;

  function automatic logic [VEC_W:0] top_set(input logic [NVEC-1:0] v);
    logic [VEC_W:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (v[i]) r = {1'b1, VEC_W'(i)};
    return r;
  endfunction

  logic [VEC_W:0]   req_top, srv_top;
  logic             req_any, srv_any;
  logic [VEC_W-1:0] req_vec, srv_vec;
  logic [3:0]       req_cls, srv_cls, tpr_cls, ppr_cls;
  logic             held, pending, take, retire;

  assign req_top = top_set(req_q);
  assign srv_top = top_set(srv_q);
  assign req_any = req_top[VEC_W];
  assign srv_any = srv_top[VEC_W];
  assign req_vec = req_top[VEC_W-1:0];
  assign srv_vec = srv_top[VEC_W-1:0];
  assign req_cls = req_vec[VEC_W-1:CLS_LO];
  assign srv_cls = srv_any ? srv_vec[VEC_W-1:CLS_LO] : 4'd0;
  assign tpr_cls = tpr_q[VEC_W-1:CLS_LO];

  assign ppr_o   = (tpr_cls >= srv_cls) ? tpr_q : {srv_cls, {CLS_LO{1'b0}}};
  assign ppr_cls = ppr_o[VEC_W-1:CLS_LO];
  assign held    = (ppr_o != '0) && (req_cls <= ppr_cls);
  assign pending = req_any && !held;
  assign irq_o   = en_q && pending;
  assign take    = ack_i && en_q && pending;
  assign retire  = eoi_i && srv_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= '0;
      srv_q       <= '0;
      lvl_q       <= '0;
      tpr_q       <= '0;
      spur_q      <= '0;
      en_q        <= 1'b0;
      deo_q       <= 1'b0;
      ack_valid_o <= 1'b0;
      ack_none_o  <= 1'b0;
      ack_vec_o   <= '0;
      eoi_bcast_o <= 1'b0;
      eoi_vec_o   <= '0;
    end else begin
      if (take) begin
        req_q[req_vec] <= 1'b0;
        srv_q[req_vec] <= 1'b1;
      end
      if (set_i) begin
        req_q[set_vec_i] <= 1'b1;
        lvl_q[set_vec_i] <= set_level_i;
      end
      if (retire) srv_q[srv_vec] <= 1'b0;
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      if (svr_we_i) begin
        spur_q <= svr_wdata_i[VEC_W-1:0];
        en_q   <= svr_wdata_i[VEC_W];
        deo_q  <= svr_deo_i;
      end
      ack_valid_o <= ack_i;
      ack_none_o  <= ack_i && !(en_q && req_any);
      ack_vec_o   <= (ack_i && en_q && req_any) ? (held ? spur_q : req_vec) : '0;
      eoi_bcast_o <= retire && lvl_q[srv_vec] && !deo_q;
      eoi_vec_o   <= retire ? srv_vec : '0;
    end
  end

  // R4
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $past(ack_i));

  // R6
  bcast_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_o |-> $past(eoi_i));

  // R10
  empty_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !srv_any) |=> !eoi_bcast_o);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svr_we_i && !svr_wdata_i[VEC_W]) |=> !irq_o);

  // R12
  tpr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we_i |=> (ppr_o[VEC_W-1:CLS_LO] >= $past(tpr_wdata_i[VEC_W-1:CLS_LO])));

  // R2
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_cls >= tpr_cls);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic set_i = 0, set_level_i = 0, tpr_we_i = 0, svr_we_i = 0, svr_deo_i = 0;
  logic ack_i = 0, eoi_i = 0;
  logic [7:0] set_vec_i = 0, tpr_wdata_i = 0;
  logic [8:0] svr_wdata_i = 0;
  logic irq_o, ack_valid_o, ack_none_o, eoi_bcast_o;
  logic [7:0] ack_vec_o, ppr_o, eoi_vec_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .set_vec_i(set_vec_i),
    .set_level_i(set_level_i), .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i),
    .svr_we_i(svr_we_i), .svr_wdata_i(svr_wdata_i), .svr_deo_i(svr_deo_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o), .ack_valid_o(ack_valid_o),
    .ack_none_o(ack_none_o), .ack_vec_o(ack_vec_o), .ppr_o(ppr_o),
    .eoi_bcast_o(eoi_bcast_o), .eoi_vec_o(eoi_vec_o));

  localparam int SETE = 0, SETL = 1, TPR = 2, SVR = 3, ACK = 4, EOI = 5;
  // {op, arg (SVR: bit9 deo, bit8 enable, 7:0 vector), irq, ppr, none, vec, bcast, pad}
  localparam int NSTEP = 27;
  localparam logic [39:0] STEPS [NSTEP] = '{
    {4'd3, 12'h1FF, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd0, 12'h041, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd1, 12'h082, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h80, 1'b0, 8'h82, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h80, 1'b0, 8'hFF, 1'b0, 5'd0},
    {4'd5, 12'h000, 1'b1, 8'h00, 1'b0, 8'h82, 1'b1, 5'd0},
    {4'd2, 12'h050, 1'b0, 8'h50, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd2, 12'h03F, 1'b1, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h40, 1'b0, 8'h41, 1'b0, 5'd0},
    {4'd5, 12'h000, 1'b0, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd5, 12'h000, 1'b0, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h3F, 1'b1, 8'h00, 1'b0, 5'd0},
    {4'd3, 12'h3F0, 1'b0, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd1, 12'h090, 1'b1, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h90, 1'b0, 8'h90, 1'b0, 5'd0},
    {4'd5, 12'h000, 1'b0, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd3, 12'h0F0, 1'b0, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd0, 12'h070, 1'b0, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h3F, 1'b1, 8'h00, 1'b0, 5'd0},
    {4'd3, 12'h1F0, 1'b1, 8'h3F, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h70, 1'b0, 8'h70, 1'b0, 5'd0},
    {4'd2, 12'h000, 1'b0, 8'h70, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd0, 12'h075, 1'b0, 8'h70, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h70, 1'b0, 8'hF0, 1'b0, 5'd0},
    {4'd3, 12'h1F5, 1'b0, 8'h70, 1'b0, 8'h00, 1'b0, 5'd0},
    {4'd4, 12'h000, 1'b0, 8'h70, 1'b0, 8'hF5, 1'b0, 5'd0},
    {4'd5, 12'h000, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic apply(input int op, input logic [11:0] arg);
    @(negedge clk);
    set_i       = (op == SETE) || (op == SETL);
    set_level_i = (op == SETL);
    set_vec_i   = arg[7:0];
    tpr_we_i    = (op == TPR);
    tpr_wdata_i = arg[7:0];
    svr_we_i    = (op == SVR);
    svr_wdata_i = arg[8:0];
    svr_deo_i   = arg[9];
    ack_i       = (op == ACK);
    eoi_i       = (op == EOI);
    @(negedge clk);
    {set_i, set_level_i, tpr_we_i, svr_we_i, ack_i, eoi_i} = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(irq_o == 0, "R11 irq", irq_o, 0);
    check(ppr_o == 0, "R11 ppr", ppr_o, 0);
    check(ack_valid_o == 0 && eoi_bcast_o == 0, "R11 strobes", ack_valid_o, 0);
    apply(ACK, 0);
    check(ack_none_o == 1, "R11 ack after reset", ack_none_o, 1);

    for (int i = 0; i < NSTEP; i++) begin
      logic [39:0] s;
      s = STEPS[i];
      apply(int'(s[39:36]), s[35:24]);
      check(irq_o == s[23], "R3/R8 irq", irq_o, s[23]);
      check(ppr_o == s[22:15], "R2/R12 ppr", ppr_o, s[22:15]);
      if (s[39:36] == 4'(ACK)) begin
        check(ack_valid_o == 1, "R4 ack valid", ack_valid_o, 1);
        check(ack_none_o == s[14], "R5/R8 ack none", ack_none_o, s[14]);
        if (!s[14]) check(ack_vec_o == s[13:6], "R1/R4/R5 ack vector", ack_vec_o, s[13:6]);
      end
      if (s[39:36] == 4'(EOI)) begin
        check(eoi_bcast_o == s[5], "R6/R7/R10 broadcast", eoi_bcast_o, s[5]);
        if (s[5]) check(eoi_vec_o == s[13:6], "R6 broadcast vector", eoi_vec_o, s[13:6]);
      end
    end

    // R9 request and acknowledge of 0x75 in one cycle: request stays
    @(negedge clk);
    set_i = 1; set_level_i = 1; set_vec_i = 8'h75; ack_i = 1;
    @(negedge clk);
    {set_i, set_level_i, ack_i} = '0;
    check(ack_vec_o == 8'h75 && !ack_none_o, "R9 ack vector", ack_vec_o, 8'h75);
    check(ppr_o == 8'h70, "R9 ppr", ppr_o, 8'h70);
    check(irq_o == 0, "R9 held", irq_o, 0);
    apply(EOI, 0);
    check(eoi_bcast_o == 1 && eoi_vec_o == 8'h75, "R9 level broadcast", eoi_vec_o, 8'h75);
    check(irq_o == 1, "R9 request kept", irq_o, 1);
    apply(ACK, 0);
    check(ack_vec_o == 8'h75, "R9 second ack", ack_vec_o, 8'h75);
    check(irq_o == 0, "R9 drained", irq_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule